// File: doc/BRIEF.md
# Byte-Stream Bus Transaction Requester

This block is the host side of a link that carries bus reads and writes over a pair of byte streams. A parallel request port takes one transaction at a time. Each request holds an address, a 16-bit write word, a write flag and a post-increment flag. The block turns the request into an outgoing byte sequence: a command byte, then as few address bytes as possible, then the write word when the request is a write. It then takes in the reply bytes and presents the status flags and any read word as a one-cycle result.

The far end keeps an address register that survives from one transaction to the next. The block keeps a local copy of that register. Only the low address bytes that differ from the copy are sent, and the copy follows any post-increment. After a failed transaction the copy is dropped, and the next request then carries the whole address. Each of the three byte-side interfaces uses a valid/ready handshake. A byte moves on a rising clock edge where both valid and ready are high.

Top module: `bus_req_serializer`

## Requirements
- R1: A request is taken only while `req_ready` is high. `req_ready` is high only when no transaction is outstanding, and it stays low from acceptance until the cycle the result pulse appears.
- R2: The request bytes go out in this order: the command byte, then the address bytes, then the write word for writes only. No further byte is offered after them.
- R3: The command byte is laid out as follows. Bits 1:0 hold the address code (0 means no address bytes, 1 means one byte, 2 means two bytes, 3 means all ADDR_BYTES bytes). Bit 2 is the write flag, bit 3 is the post-increment flag, and bits 7:4 are zero.
- R4: The address bytes are the low bytes of the request address, sent most-significant first. The code is the smallest one that covers the highest-numbered byte that differs from the local copy.
- R5: After reset the local copy is invalid, so the first request sends every address byte (code 3).
- R6: The 16-bit write word is sent as two bytes, most-significant byte first.
- R7: The first reply byte is the status byte. Bit 1 (bus error) is reported on `rsp_buserr` and bit 3 (overflow) on `rsp_overflow`.
- R8: Two data bytes follow the status byte only when the request was a read and status bit 1 is clear. They arrive least-significant byte first and are joined into `rsp_rdata`. In every other case the result comes after the status byte alone, with `rsp_rdata` equal to zero.
- R9: After a clean transaction with post-increment set, the local copy becomes the request address plus one, wrapping at the top of the address range.
- R10: A bus error or a protocol error invalidates the local copy.
- R11: `rsp_proterr` is set when status bit 0 differs from the request's write flag. The block still takes exactly the reply bytes it expected for the request it sent.
- R12: `rsp_valid` is a one-cycle pulse in the cycle after the last reply byte is taken. The result fields hold their values until the next result.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 8*ADDR_BYTES | Target address |
| req_wdata | input | 8*DATA_BYTES | Write word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_incr | input | 1 | Ask the far end to post-increment its address |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Outgoing byte taken |
| tx_byte | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Reply byte present |
| rx_ready | output | 1 | Block can take a reply byte |
| rx_byte | input | 8 | Reply byte |
| rsp_valid | output | 1 | Result pulse |
| rsp_rdata | output | 8*DATA_BYTES | Read word, zero when there is none |
| rsp_buserr | output | 1 | Far end reported a bus error |
| rsp_overflow | output | 1 | Far end reported an overflow |
| rsp_proterr | output | 1 | Echoed write flag did not match |

## Verification
The requests follow one another so that the address code goes through all of its values. The first request after reset exposes a missing invalidation. Repeating an address yields code 0. Changing only byte 0, only byte 1, or byte 2 selects codes 1, 2 and 3, which exposes a wrong priority among the byte comparisons. A post-increment across the all-ones address tells a wrapped copy from a stale one. Replies with a bus error, an overflow and a mismatched write echo show whether the data bytes are taken or skipped correctly and whether the copy is dropped. Stalls on both byte streams check that handshakes with gaps give the same byte order as back-to-back transfers.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_STAT,
        PH_RDATA
    } phase_e;

    localparam int STAT_WE_BIT   = 0;
    localparam int STAT_BERR_BIT = 1;
    localparam int STAT_OVF_BIT  = 3;
    localparam logic [1:0] CODE_FULL = 2'd3;
endpackage

// File: rtl/bsr_addr_shadow.sv
module bsr_addr_shadow #(
    parameter int ADDR_BYTES = 4,
    localparam int AW = 8 * ADDR_BYTES,
    localparam int CW = $clog2(ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] probe_addr,
    output logic [1:0]    code_o,
    output logic [CW-1:0] nbytes_o,
    input  logic          upd_en,
    input  logic          upd_inval,
    input  logic          upd_incr,
    input  logic [AW-1:0] upd_addr
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          valid;
    } shadow_s;

    shadow_s sh_d, sh_q;
    logic [ADDR_BYTES-1:0] byte_diff;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cmp
        assign byte_diff[g] = (sh_q.addr[g*8 +: 8] != probe_addr[g*8 +: 8]);
    end

    always_comb begin
        if (!sh_q.valid || (|byte_diff[ADDR_BYTES-1:2])) begin
            code_o = bsr_pkg::CODE_FULL;
        end else if (byte_diff[1]) begin
            code_o = 2'd2;
        end else if (byte_diff[0]) begin
            code_o = 2'd1;
        end else begin
            code_o = 2'd0;
        end
        nbytes_o = (code_o == bsr_pkg::CODE_FULL) ? CW'(ADDR_BYTES) : CW'(code_o);
    end

    always_comb begin
        sh_d = sh_q;
        if (upd_en) begin
            if (upd_inval) begin
                sh_d.valid = 1'b0;
            end else begin
                sh_d.addr  = upd_addr + AW'(upd_incr);
                sh_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/bsr_tx_sel.sv
module bsr_tx_sel #(
    parameter int ADDR_BYTES = 4,
    parameter int DATA_BYTES = 2,
    parameter int IW = 2,
    localparam int AW = 8 * ADDR_BYTES,
    localparam int DW = 8 * DATA_BYTES
) (
    input  bsr_pkg::phase_e phase,
    input  logic [7:0]      cmd_byte,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [IW-1:0]   idx,
    output logic [7:0]      byte_o,
    output logic            valid_o
);
    always_comb begin
        byte_o  = 8'h00;
        valid_o = 1'b0;
        case (phase)
            bsr_pkg::PH_CMD: begin
                byte_o  = cmd_byte;
                valid_o = 1'b1;
            end
            bsr_pkg::PH_ADDR: begin
                byte_o  = addr[idx*8 +: 8];
                valid_o = 1'b1;
            end
            bsr_pkg::PH_WDATA: begin
                byte_o  = wdata[idx*8 +: 8];
                valid_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_req_serializer.sv
module bus_req_serializer #(
    parameter int ADDR_BYTES = 4,
    parameter int DATA_BYTES = 2,
    localparam int AW   = 8 * ADDR_BYTES,
    localparam int DW   = 8 * DATA_BYTES,
    localparam int CW   = $clog2(ADDR_BYTES + 1),
    localparam int MAXB = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES,
    localparam int IW   = (MAXB > 2) ? $clog2(MAXB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          req_incr,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_byte,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_byte,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_buserr,
    output logic          rsp_overflow,
    output logic          rsp_proterr
);
    import bsr_pkg::*;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          write;
        logic          incr;
        logic [1:0]    code;
        logic [CW-1:0] nbytes;
        logic [IW-1:0] idx;
        logic [DW-1:0] acc;
        logic          berr;
        logic          ovf;
        logic          perr;
        logic          rsp_v;
        logic [DW-1:0] rsp_data;
        logic          rsp_berr;
        logic          rsp_ovf;
        logic          rsp_perr;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [1:0]    sh_code;
    logic [CW-1:0] sh_nbytes;
    logic          upd_en;
    logic          upd_inval;
    logic          finish;
    logic [7:0]    cmd_byte;

    bsr_addr_shadow #(.ADDR_BYTES(ADDR_BYTES)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_addr (req_addr),
        .code_o     (sh_code),
        .nbytes_o   (sh_nbytes),
        .upd_en     (upd_en),
        .upd_inval  (upd_inval),
        .upd_incr   (ctl_q.incr),
        .upd_addr   (ctl_q.addr)
    );

    assign cmd_byte = {4'b0000, ctl_q.incr, ctl_q.write, ctl_q.code};

    bsr_tx_sel #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES),
        .IW         (IW)
    ) u_txsel (
        .phase    (ctl_q.phase),
        .cmd_byte (cmd_byte),
        .addr     (ctl_q.addr),
        .wdata    (ctl_q.wdata),
        .idx      (ctl_q.idx),
        .byte_o   (tx_byte),
        .valid_o  (tx_valid)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        finish      = 1'b0;
        upd_en      = 1'b0;
        upd_inval   = 1'b0;

        case (ctl_q.phase)
            PH_IDLE: if (req_valid) begin
                ctl_d.addr   = req_addr;
                ctl_d.wdata  = req_wdata;
                ctl_d.write  = req_write;
                ctl_d.incr   = req_incr;
                ctl_d.code   = sh_code;
                ctl_d.nbytes = sh_nbytes;
                ctl_d.acc    = '0;
                ctl_d.phase  = PH_CMD;
            end
            PH_CMD: if (tx_ready) begin
                if (ctl_q.nbytes != '0) begin
                    ctl_d.phase = PH_ADDR;
                    ctl_d.idx   = IW'(ctl_q.nbytes - 1'b1);
                end else if (ctl_q.write) begin
                    ctl_d.phase = PH_WDATA;
                    ctl_d.idx   = IW'(DATA_BYTES - 1);
                end else begin
                    ctl_d.phase = PH_STAT;
                end
            end
            PH_ADDR: if (tx_ready) begin
                if (ctl_q.idx != '0) begin
                    ctl_d.idx = ctl_q.idx - 1'b1;
                end else if (ctl_q.write) begin
                    ctl_d.phase = PH_WDATA;
                    ctl_d.idx   = IW'(DATA_BYTES - 1);
                end else begin
                    ctl_d.phase = PH_STAT;
                end
            end
            PH_WDATA: if (tx_ready) begin
                if (ctl_q.idx != '0) ctl_d.idx   = ctl_q.idx - 1'b1;
                else                 ctl_d.phase = PH_STAT;
            end
            PH_STAT: if (rx_valid) begin
                ctl_d.berr = rx_byte[STAT_BERR_BIT];
                ctl_d.ovf  = rx_byte[STAT_OVF_BIT];
                ctl_d.perr = (rx_byte[STAT_WE_BIT] != ctl_q.write);
                if (!ctl_q.write && !rx_byte[STAT_BERR_BIT]) begin
                    ctl_d.phase = PH_RDATA;
                    ctl_d.idx   = '0;
                end else begin
                    finish = 1'b1;
                end
            end
            PH_RDATA: if (rx_valid) begin
                ctl_d.acc[ctl_q.idx*8 +: 8] = rx_byte;
                if (ctl_q.idx == IW'(DATA_BYTES - 1)) finish    = 1'b1;
                else                                  ctl_d.idx = ctl_q.idx + 1'b1;
            end
            default: ctl_d.phase = PH_IDLE;
        endcase

        if (finish) begin
            ctl_d.phase    = PH_IDLE;
            ctl_d.rsp_v    = 1'b1;
            ctl_d.rsp_data = ctl_d.acc;
            ctl_d.rsp_berr = ctl_d.berr;
            ctl_d.rsp_ovf  = ctl_d.ovf;
            ctl_d.rsp_perr = ctl_d.perr;
            upd_en         = 1'b1;
            upd_inval      = ctl_d.berr | ctl_d.perr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready    = (ctl_q.phase == PH_IDLE);
    assign rx_ready     = (ctl_q.phase == PH_STAT) || (ctl_q.phase == PH_RDATA);
    assign rsp_valid    = ctl_q.rsp_v;
    assign rsp_rdata    = ctl_q.rsp_data;
    assign rsp_buserr   = ctl_q.rsp_berr;
    assign rsp_overflow = ctl_q.rsp_ovf;
    assign rsp_proterr  = ctl_q.rsp_perr;
endmodule

module bsr_check #(
    parameter int DATA_BYTES = 2,
    localparam int DW = 8 * DATA_BYTES
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic          req_incr,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_byte,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [7:0]    rx_byte,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic          rsp_buserr,
    input logic          rsp_proterr
);
    logic       we_q;
    logic       first_q;
    logic [7:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            first_q <= 1'b0;
            stat_q  <= 8'h00;
        end else if (req_valid && req_ready) begin
            we_q    <= req_write;
            first_q <= 1'b1;
        end else if (rx_valid && rx_ready && first_q) begin
            stat_q  <= rx_byte;
            first_q <= 1'b0;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!tx_valid && !rx_ready)); // R1
    AST_CMD_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (tx_valid && tx_byte[7:4] == 4'h0
            && tx_byte[2] == $past(req_write) && tx_byte[3] == $past(req_incr))); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R13
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_BERR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_buserr == stat_q[1])); // R7
    AST_NO_RDATA_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && stat_q[1]) |-> (rsp_rdata == '0)); // R8
    AST_PROTERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_proterr == (stat_q[0] != we_q))); // R11
endmodule

bind bus_req_serializer bsr_check #(.DATA_BYTES(DATA_BYTES)) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_incr    (req_incr),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_byte     (tx_byte),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_byte     (rx_byte),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_buserr  (rsp_buserr),
    .rsp_proterr (rsp_proterr)
);

// File: tb/bus_req_serializer_test.sv
module bus_req_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_incr = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_byte = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rsp_buserr;
    logic        rsp_overflow;
    logic        rsp_proterr;

    always #2.5 clk = ~clk;

    bus_req_serializer #(.ADDR_BYTES(4), .DATA_BYTES(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_incr(req_incr),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_buserr(rsp_buserr),
        .rsp_overflow(rsp_overflow), .rsp_proterr(rsp_proterr)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] m_shadow = '0;
    bit          m_valid = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One transaction; expectations come from the requirement model kept here.
    task automatic txn(input logic [31:0] addr, input logic [15:0] wd,
                       input bit wr, input bit inc, input logic [7:0] status,
                       input logic [15:0] rdval, input int gap, input string tag);
        logic [7:0]  exp_tx [0:7];
        logic [7:0]  resp [0:2];
        logic [31:0] diff;
        logic [1:0]  code;
        logic [15:0] exp_rd;
        int ne, nr, na, got, cyc, k;
        bit perr;
        diff = addr ^ m_shadow;
        if (!m_valid || diff[31:16] != 0) code = 2'd3;
        else if (diff[15:8] != 0)         code = 2'd2;
        else if (diff[7:0] != 0)          code = 2'd1;
        else                              code = 2'd0;
        na = (code == 2'd3) ? 4 : int'(code);
        exp_tx[0] = {4'h0, inc, wr, code};
        ne = 1;
        for (int i = na - 1; i >= 0; i--) begin
            exp_tx[ne] = addr[i*8 +: 8];
            ne++;
        end
        if (wr) begin
            exp_tx[ne] = wd[15:8];
            exp_tx[ne+1] = wd[7:0];
            ne += 2;
        end
        resp[0] = status;
        nr = 1;
        exp_rd = 16'h0000;
        if (!wr && !status[1]) begin
            resp[1] = rdval[7:0];
            resp[2] = rdval[15:8];
            nr = 3;
            exp_rd = rdval;
        end
        perr = (status[0] != wr);

        @(negedge clk);
        req_addr = addr; req_wdata = wd; req_write = wr; req_incr = inc;
        req_valid = 1'b1;
        k = 0;
        forever begin
            #1;
            if (req_ready || k > 50) break;
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        req_valid = 1'b0;

        got = 0;
        cyc = 0;
        while (got < ne && cyc < 200) begin
            tx_ready = (gap > 0 && (cyc % (gap + 1)) != 0) ? 1'b0 : 1'b1;
            #1;
            if (cyc == 0) chk("R1", {tag, " req_ready while busy"}, 32'(req_ready), 32'd0);
            if (tx_valid && tx_ready) begin
                chk(tag, $sformatf("tx byte %0d", got), 32'(tx_byte), 32'(exp_tx[got]));
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        tx_ready = 1'b0;
        chk("R2", {tag, " tx byte count"}, 32'(got), 32'(ne));
        #1;
        chk("R2", {tag, " no extra tx byte"}, 32'(tx_valid), 32'd0);

        for (int i = 0; i < nr; i++) begin
            repeat (gap) begin
                rx_valid = 1'b0;
                @(negedge clk);
                #1;
            end
            rx_valid = 1'b1;
            rx_byte = resp[i];
            k = 0;
            forever begin
                #1;
                if (rx_ready || k > 50) break;
                @(negedge clk);
                k++;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0;
        #1;
        chk("R12", {tag, " rsp_valid pulse"}, 32'(rsp_valid), 32'd1);
        chk("R8", {tag, " rsp_rdata"}, 32'(rsp_rdata), 32'(exp_rd));
        chk("R7", {tag, " rsp_buserr"}, 32'(rsp_buserr), 32'(status[1]));
        chk("R7", {tag, " rsp_overflow"}, 32'(rsp_overflow), 32'(status[3]));
        chk("R11", {tag, " rsp_proterr"}, 32'(rsp_proterr), 32'(perr));
        chk("R8", {tag, " rx_ready after reply"}, 32'(rx_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R12", {tag, " rsp_valid drops"}, 32'(rsp_valid), 32'd0);
        chk("R12", {tag, " rdata held"}, 32'(rsp_rdata), 32'(exp_rd));

        if (status[1] || perr) m_valid = 1'b0;
        else begin
            m_shadow = addr + 32'(inc);
            m_valid  = 1'b1;
        end
    endtask

    task automatic t_reset_state;
        #1;
        chk("R1", "reset req_ready", 32'(req_ready), 32'd1);
        chk("R2", "reset tx_valid", 32'(tx_valid), 32'd0);
        chk("R8", "reset rx_ready", 32'(rx_ready), 32'd0);
        chk("R12", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_first_write;   // R5 R6: full address, write word MSB first
        txn(32'h1234_5678, 16'hBEEF, 1'b1, 1'b0, 8'h01, 16'h0, 0, "R5/R6");
    endtask

    task automatic t_same_addr_read; // R4 code 0, R8 LSB-first read data
        txn(32'h1234_5678, 16'h0, 1'b0, 1'b0, 8'h00, 16'h1234, 0, "R4/R8");
    endtask

    task automatic t_low_byte_incr;  // R4 code 1, R9 post-increment, R7 overflow
        txn(32'h1234_5699, 16'h0, 1'b0, 1'b1, 8'h08, 16'hA55A, 0, "R4/R7/R9");
        txn(32'h1234_569A, 16'h0F0F, 1'b1, 1'b0, 8'h01, 16'h0, 2, "R9/R13");
    endtask

    task automatic t_two_and_full;   // R3 R4 codes 2 and 3
        txn(32'h1234_AB9A, 16'h1357, 1'b1, 1'b0, 8'h01, 16'h0, 0, "R3/R4");
        txn(32'h12AB_AB9A, 16'h0, 1'b0, 1'b0, 8'h00, 16'hC001, 1, "R3/R4");
    endtask

    task automatic t_bus_error;      // R8 no data after error, R10 copy dropped
        txn(32'h12AB_AB9A, 16'h0, 1'b0, 1'b0, 8'h02, 16'hFFFF, 0, "R8/R10");
        txn(32'h12AB_AB9A, 16'h2468, 1'b1, 1'b0, 8'h03, 16'h0, 0, "R10");
        txn(32'h12AB_AB9A, 16'h0, 1'b0, 1'b0, 8'h00, 16'h8001, 0, "R10");
    endtask

    task automatic t_proto_error;    // R11 mismatched echo, bytes still consumed
        txn(32'h12AB_AB9B, 16'h0, 1'b0, 1'b0, 8'h01, 16'h7E81, 0, "R11");
        txn(32'h12AB_AB9B, 16'h1111, 1'b1, 1'b0, 8'h00, 16'h0, 0, "R10/R11");
        txn(32'h12AB_AB9B, 16'h2222, 1'b1, 1'b0, 8'h01, 16'h0, 0, "R10");
    endtask

    task automatic t_incr_wrap;      // R9 wrap of the local copy
        txn(32'hFFFF_FFFF, 16'h0, 1'b0, 1'b1, 8'h00, 16'h0102, 0, "R9");
        txn(32'h0000_0000, 16'h0, 1'b0, 1'b0, 8'h00, 16'h0304, 0, "R9");
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_first_write();
        t_same_addr_read();
        t_low_byte_incr();
        t_two_and_full();
        t_bus_error();
        t_proto_error();
        t_incr_wrap();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule